// File: doc/BRIEF.md
# Bus Wait-State Generator with Timeout

This block stretches each local memory or I/O access made by a processor or a DMA master. A one-clock access strobe, sampled with a cycle-type code, raises a WAIT output toward the master. WAIT stays raised until two things are true: the minimum number of wait states for that kind of cycle has passed, and the addressed device has acknowledged.

A retriggerable watchdog protects the bus against a device that never answers. It restarts on every strobe. If it runs out before an acknowledge arrives, it forces WAIT low, emits a one-clock timeout interrupt pulse and sets a sticky timeout flag. A dedicated clear input resets that flag.

The minimum wait count depends on who is mastering the bus and, for DMA, on the direction of the transfer. A DMA cycle that reads a peripheral and writes memory needs one more wait state than a DMA cycle going the other way. The timeout length and each minimum are parameters counted in clock cycles.

Top module: `bus_wait_gen`

## Requirements
- R1: A strobe sampled at a rising edge makes `wait_o` high from that edge on. `wait_o` stays high at least until the access is released.
- R2: The minimum number of cycles `wait_o` stays high depends on the cycle type latched with the strobe. The encodings are: 2'b00 CPU memory access (MIN_CPU_MEM, default 1), 2'b01 CPU I/O access (MIN_CPU_IO, default 1), 2'b10 DMA memory read with peripheral write (MIN_DMA_M2P, default 1), and 2'b11 DMA peripheral read with memory write (MIN_DMA_P2M, default 2).
- R3: Let the high cycles of `wait_o` be numbered 0, 1, 2 … from the strobe, and let `ack` be sampled high in wait cycle k, with k < TMO_CYCLES. Then `wait_o` stays high for exactly max(N, k+1) cycles, where N is the minimum of R2. No timeout follows. An `ack` sampled while no access is pending has no effect: it does not release a later access.
- R4: If no `ack` is sampled in wait cycles 0 to TMO_CYCLES-1, `wait_o` stays high for exactly TMO_CYCLES cycles. `tmo_irq` is then high for exactly one clock, in the first cycle `wait_o` is low. An `ack` in the last of those cycles wins over the timeout.
- R5: `tmo_flag` becomes high together with `tmo_irq`. It stays high until `flag_clr` is sampled high, and is low the cycle after. When a timeout and `flag_clr` coincide, the flag is set.
- R6: A strobe sampled while `wait_o` is high restarts the access. The wait-cycle numbering of R3 and R4 restarts at 0 on the following cycle, and any earlier `ack` is discarded.
- R7: While `rst_n` is low, `wait_o`, `tmo_irq` and `tmo_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Access start, one clock per memory or I/O access |
| cyc_type | input | 2 | Cycle type sampled with strobe (encoding in R2) |
| ack | input | 1 | Acknowledge from the addressed device |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| wait_o | output | 1 | Wait request to the bus master |
| tmo_irq | output | 1 | One-clock bus-timeout interrupt pulse |
| tmo_flag | output | 1 | Sticky timeout status |

## Verification
On every cycle the assertions check the following:
- a strobe raises WAIT;
- no access ends before its type's minimum;
- no wait period exceeds the timeout length;
- the interrupt is a single pulse that coincides with a low WAIT and a set flag;
- the flag only falls after a clear;
- an acknowledged access never times out.

Only the bench's scenarios can show the exact lengths max(N, k+1) and TMO_CYCLES. The scenarios sweep every cycle type against every acknowledge delay. They also show that a stale acknowledge given while idle is forgotten, and that a strobe in the middle of an access restarts the full timeout.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [1:0] {
    CYC_CPU_MEM = 2'b00,
    CYC_CPU_IO  = 2'b01,
    CYC_DMA_M2P = 2'b10,
    CYC_DMA_P2M = 2'b11
  } cyc_e;

  localparam int NUM_CYC = 4;

  function automatic int min_for(input logic [1:0] t, input int m_mem,
                                 input int m_io, input int m_m2p, input int m_p2m);
    case (t)
      CYC_CPU_MEM: min_for = m_mem;
      CYC_CPU_IO:  min_for = m_io;
      CYC_DMA_M2P: min_for = m_m2p;
      default:     min_for = m_p2m;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    max4 = m;
  endfunction

endpackage

// File: rtl/ws_min_select.sv
module ws_min_select #(
  parameter int MW          = 2,
  parameter int MIN_CPU_MEM = 1,
  parameter int MIN_CPU_IO  = 1,
  parameter int MIN_DMA_M2P = 1,
  parameter int MIN_DMA_P2M = 2
) (
  input  logic [1:0]    cyc_type,
  output logic [MW-1:0] min_cnt
);
  import ws_pkg::*;

  logic [MW-1:0] table_q [NUM_CYC];

  // One constant per cycle type, built from the package rule.
  for (genvar g = 0; g < NUM_CYC; g++) begin : g_tab
    assign table_q[g] = MW'(min_for(2'(g), MIN_CPU_MEM, MIN_CPU_IO,
                                    MIN_DMA_M2P, MIN_DMA_P2M));
  end

  assign min_cnt = table_q[cyc_type];

endmodule

// File: rtl/ws_downcount.sv
module ws_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - W'(1);
  end

endmodule

// File: rtl/ws_wait_ctrl.sv
module ws_wait_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic min_done,
  input  logic expire,
  input  logic flag_clr,
  output logic busy,
  output logic tmo_irq,
  output logic tmo_flag
);

  logic ack_seen;
  logic acked;
  logic release_now;
  logic tmo_evt;

  assign acked       = ack || ack_seen;
  assign release_now = busy && !start && min_done && (acked || expire);
  assign tmo_evt     = busy && !start && expire && !acked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ack_seen <= 1'b0;
      tmo_irq  <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      // Wait flag: a new strobe always wins over a release.
      if (start)            busy <= 1'b1;
      else if (release_now) busy <= 1'b0;

      // Early acknowledge held until the minimum has passed.
      if (start || release_now) ack_seen <= 1'b0;
      else if (busy && ack)     ack_seen <= 1'b1;

      tmo_irq <= tmo_evt;

      // Set has priority over clear.
      if (tmo_evt)       tmo_flag <= 1'b1;
      else if (flag_clr) tmo_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int TMO_CYCLES  = 256,
  parameter int MIN_CPU_MEM = 1,
  parameter int MIN_CPU_IO  = 1,
  parameter int MIN_DMA_M2P = 1,
  parameter int MIN_DMA_P2M = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [1:0] cyc_type,
  input  logic       ack,
  input  logic       flag_clr,
  output logic       wait_o,
  output logic       tmo_irq,
  output logic       tmo_flag
);
  import ws_pkg::*;

  localparam int MAXMIN = max4(MIN_CPU_MEM, MIN_CPU_IO, MIN_DMA_M2P, MIN_DMA_P2M);
  localparam int MW     = $clog2(MAXMIN + 1);
  localparam int TW     = $clog2(TMO_CYCLES + 1);

  logic          busy;
  logic          run;
  logic [MW-1:0] min_load;
  logic [MW-1:0] min_cnt;
  logic [TW-1:0] tmo_cnt;
  logic          min_done;
  logic          expire;

  assign run = busy && !strobe;

  ws_min_select #(
    .MW(MW), .MIN_CPU_MEM(MIN_CPU_MEM), .MIN_CPU_IO(MIN_CPU_IO),
    .MIN_DMA_M2P(MIN_DMA_M2P), .MIN_DMA_P2M(MIN_DMA_P2M)
  ) u_minsel (
    .cyc_type(cyc_type),
    .min_cnt (min_load)
  );

  ws_downcount #(.W(MW)) u_mincnt (
    .clk(clk), .rst_n(rst_n), .load(strobe), .load_val(min_load),
    .run(run), .cnt(min_cnt)
  );

  ws_downcount #(.W(TW)) u_tmocnt (
    .clk(clk), .rst_n(rst_n), .load(strobe), .load_val(TW'(TMO_CYCLES)),
    .run(run), .cnt(tmo_cnt)
  );

  // Minimum reached when this wait cycle is the last one required.
  assign min_done = (min_cnt <= MW'(1));
  assign expire   = busy && (tmo_cnt == TW'(1));

  ws_wait_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(strobe), .ack(ack),
    .min_done(min_done), .expire(expire), .flag_clr(flag_clr),
    .busy(busy), .tmo_irq(tmo_irq), .tmo_flag(tmo_flag)
  );

  assign wait_o = busy;

endmodule

// File: rtl/ws_wait_checker.sv
module ws_wait_checker #(
  parameter int TMO_CYCLES  = 256,
  parameter int MIN_CPU_MEM = 1,
  parameter int MIN_CPU_IO  = 1,
  parameter int MIN_DMA_M2P = 1,
  parameter int MIN_DMA_P2M = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic [1:0] cyc_type,
  input logic       ack,
  input logic       flag_clr,
  input logic       wait_o,
  input logic       tmo_irq,
  input logic       tmo_flag
);
  import ws_pkg::*;

  logic [1:0]  lat_type;
  logic [31:0] run_len;
  int          need;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_type <= 2'b00;
      run_len  <= '0;
    end else if (strobe) begin
      lat_type <= cyc_type;
      run_len  <= '0;
    end else if (wait_o) begin
      run_len <= run_len + 32'd1;
    end
  end

  assign need = min_for(lat_type, MIN_CPU_MEM, MIN_CPU_IO, MIN_DMA_M2P, MIN_DMA_P2M);

  a_r1_strobe_sets_wait: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> wait_o);

  a_r2_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_o) |-> (run_len >= 32'(need)));

  a_r3_ack_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && ack && !strobe) |=> !tmo_irq);

  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |=> !tmo_irq);

  a_r4_irq_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> !wait_o);

  a_r5_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> tmo_flag);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> $past(flag_clr));

  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (run_len < 32'(TMO_CYCLES)));

endmodule

bind bus_wait_gen ws_wait_checker #(
  .TMO_CYCLES(TMO_CYCLES), .MIN_CPU_MEM(MIN_CPU_MEM), .MIN_CPU_IO(MIN_CPU_IO),
  .MIN_DMA_M2P(MIN_DMA_M2P), .MIN_DMA_P2M(MIN_DMA_P2M)
) u_ws_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .cyc_type(cyc_type), .ack(ack),
  .flag_clr(flag_clr), .wait_o(wait_o), .tmo_irq(tmo_irq), .tmo_flag(tmo_flag)
);

// File: tb/test_bus_wait_gen.sv
module test_bus_wait_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [1:0] cyc_type = 2'b00;
  logic       ack = 1'b0;
  logic       flag_clr = 1'b0;
  logic       wait_o, tmo_irq, tmo_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bus_wait_gen #(.TMO_CYCLES(TMO)) i_bus_wait_gen (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cyc_type(cyc_type), .ack(ack),
    .flag_clr(flag_clr), .wait_o(wait_o), .tmo_irq(tmo_irq), .tmo_flag(tmo_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min_of(input int t);
    case (t)
      0: return 1;
      1: return 1;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R5 flag low after clear", tmo_flag, 0);
  endtask

  // Strobe, then ack in wait cycle k (k >= TMO means no ack).
  task automatic trial(input int t, input int k);
    int len, irqs, irq_at, exp_len;
    len = 0; irqs = 0; irq_at = -1;
    @(negedge clk) begin strobe = 1'b1; cyc_type = 2'(t); end
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      strobe = 1'b0;
      ack = (i == k);
      if (wait_o) len++;
      if (tmo_irq) begin irqs++; irq_at = i; end
    end
    ack = 1'b0;
    if (k < TMO) begin
      exp_len = (min_of(t) > k + 1) ? min_of(t) : k + 1;
      check($sformatf("R3 len type=%0d k=%0d", t, k), len, exp_len);
      check($sformatf("R3 no irq type=%0d k=%0d", t, k), irqs, 0);
      if (t == 3 && k == 0) check("R2 dma p2m min", len, 2);
    end else begin
      check($sformatf("R4 len type=%0d", t), len, TMO);
      check($sformatf("R4 irq count type=%0d", t), irqs, 1);
      check($sformatf("R4 irq cycle type=%0d", t), irq_at, TMO);
      check("R5 flag sticky", tmo_flag, 1);
      clear_flag();
    end
  endtask

  initial begin
    int len, irqs;
    idle(3);
    check("R7 wait in reset", wait_o, 0);
    check("R7 irq in reset", tmo_irq, 0);
    check("R7 flag in reset", tmo_flag, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R1 wait raised the cycle after a strobe
    @(negedge clk) begin strobe = 1'b1; cyc_type = 2'b00; end
    @(negedge clk) strobe = 1'b0;
    check("R1 wait after strobe", wait_o, 1);
    ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    check("R1 wait released", wait_o, 0);
    idle(2);

    // R2 R3 R4 sweep over every type and ack delay
    for (int t = 0; t < 4; t++)
      for (int k = 0; k <= TMO + 1; k++) begin
        trial(t, k);
        idle(2);
      end

    // R3 stale ack while idle is ignored
    ack = 1'b1;
    idle(3);
    check("R3 idle ack no wait", wait_o, 0);
    ack = 1'b0;
    trial(0, TMO + 2);
    idle(2);

    // R6 restart in the middle of an access
    len = 0; irqs = 0;
    @(negedge clk) begin strobe = 1'b1; cyc_type = 2'b00; end
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      strobe = (i == 4);
      if (wait_o) len++;
      if (tmo_irq) irqs++;
    end
    strobe = 1'b0;
    check("R6 restart length", len, 5 + TMO);
    check("R6 restart irq", irqs, 1);
    clear_flag();

    // R6 early ack discarded by restart (type 3 keeps wait for ack in cycle 0)
    len = 0;
    @(negedge clk) begin strobe = 1'b1; cyc_type = 2'b11; end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      strobe = (i == 1);
      ack = (i == 0);
      if (wait_o) len++;
    end
    strobe = 1'b0; ack = 1'b0;
    check("R6 ack discarded", len, 2 + TMO);

    // R5 timeout coinciding with clear leaves flag set
    clear_flag();
    @(negedge clk) begin strobe = 1'b1; cyc_type = 2'b00; end
    @(negedge clk) strobe = 1'b0;
    idle(TMO - 1);
    flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R5 set wins over clear", tmo_flag, 1);
    clear_flag();

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule